// File: doc/BRIEF.md
# Synchronous dual-port burst RAM

This block is a true dual-port static RAM with two fully independent synchronous ports, A and B. Each port runs on its own clock and synchronous reset. On every rising edge a port captures its address, controls and write data. Either port may read or write any word at any time, and both may use the same word, with no busy or arbitration signal. A word holds two byte lanes, and each lane has its own active-low enable for both writing and reading.

Each port owns a burst address counter, and that counter is the access address. On an edge the counter can be cleared, loaded from the external address, advanced by one, or held. The access of that cycle uses the new value, so a burst is one load followed by advance cycles. Two chip selects of opposite polarity allow depth expansion without an external decoder. A per-port mode input chooses a read latency of one edge (flow-through) or two edges (pipelined). Read data is given as a data word plus a per-lane valid flag, and the valid flag stands in for an output driver enable.

Top module: `dpr_burst_ram`

## Requirements
- R1: A word written by one port can be read by the other port through a read captured at any later edge. Both ports may read the same word in the same cycle.
- R2: On each rising edge the counter takes the first true case of this list: 0 when clr_n is low; addr when ld_n is low; its value plus one when adv_n is low; otherwise it holds. The read or write of that cycle uses the new counter value.
- R3: Advancing from address DEPTH-1 wraps the counter to 0.
- R4: With pipe_mode low at the capturing edge, read data and valid appear right after that edge and last one cycle.
- R5: With pipe_mode high at the capturing edge, read data and valid appear one edge later than under R4.
- R6: A port is selected only when sel_n is low and sel is high. A deselected port writes nothing, and its captured cycle produces no valid lane.
- R7: ub_n enables lane 1 (data bits [2*LANE_W-1:LANE_W]) and lb_n enables lane 0 (bits [LANE_W-1:0]), both active low. A write changes only the enabled lanes. A read raises dvld only for the enabled lanes, and a lane whose dvld is low reads as zero.
- R8: rd_wr high means read and low means write. A lane's dvld rises only for a selected read captured with oe_n low. A write cycle produces no valid lane.
- R9: While reset is high, the port's dvld is 0 from the next edge on. Reset clears the counter, so a read cycle with no counter operation after reset accesses address 0.
- R10: The counter follows R2 whether or not the port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| addr_a | input | ADDR_W | Port A external address for counter load |
| din_a | input | 2*LANE_W | Port A write data |
| sel_n_a | input | 1 | Port A select, active low |
| sel_a | input | 1 | Port A select, active high |
| rd_wr_a | input | 1 | Port A 1 = read, 0 = write |
| oe_n_a | input | 1 | Port A output enable, active low |
| ub_n_a | input | 1 | Port A lane 1 enable, active low |
| lb_n_a | input | 1 | Port A lane 0 enable, active low |
| ld_n_a | input | 1 | Port A counter load, active low |
| adv_n_a | input | 1 | Port A counter advance, active low |
| clr_n_a | input | 1 | Port A counter clear, active low |
| pipe_mode_a | input | 1 | Port A 1 = pipelined, 0 = flow-through |
| dout_a | output | 2*LANE_W | Port A read data |
| dvld_a | output | 2 | Port A per-lane read valid |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| addr_b | input | ADDR_W | Port B external address for counter load |
| din_b | input | 2*LANE_W | Port B write data |
| sel_n_b | input | 1 | Port B select, active low |
| sel_b | input | 1 | Port B select, active high |
| rd_wr_b | input | 1 | Port B 1 = read, 0 = write |
| oe_n_b | input | 1 | Port B output enable, active low |
| ub_n_b | input | 1 | Port B lane 1 enable, active low |
| lb_n_b | input | 1 | Port B lane 0 enable, active low |
| ld_n_b | input | 1 | Port B counter load, active low |
| adv_n_b | input | 1 | Port B counter advance, active low |
| clr_n_b | input | 1 | Port B counter clear, active low |
| pipe_mode_b | input | 1 | Port B 1 = pipelined, 0 = flow-through |
| dout_b | output | 2*LANE_W | Port B read data |
| dvld_b | output | 2 | Port B per-lane read valid |

## Verification
The bench targets these corner cases:
- Counter priority with clear, load and advance asserted together; a design with the wrong order reads the loaded or incremented word instead of word 0.
- The wrap from the top address; a counter that saturates or carries out of range reads the wrong word.
- Reads from port B right after port A writes the same word, and lane-masked writes followed by full reads. A wrong last-writer choice or a lane mask that leaks returns stale or clobbered lanes.
- A counter moved while the port is deselected, so a design that freezes the counter when deselected reads from the old address.
- Random traffic on both ports with latency changes in the middle of the run; a data path off by one stage shows neighbouring burst words.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // A word is always split into two byte lanes.
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_STEP  = 2'd1,
        CNT_LOAD  = 2'd2,
        CNT_CLEAR = 2'd3
    } cnt_op_e;

    // Read controls captured at the edge, travelling with the data.
    typedef struct packed {
        logic             rd;
        logic [LANES-1:0] lane;
        logic             pipe;
    } rd_ctrl_t;

    function automatic cnt_op_e decode_cnt(input logic clr_n, input logic ld_n,
                                           input logic adv_n);
        if (!clr_n)     return CNT_CLEAR;
        else if (!ld_n) return CNT_LOAD;
        else if (!adv_n) return CNT_STEP;
        return CNT_HOLD;
    endfunction

    function automatic logic port_selected(input logic sel_n, input logic sel);
        return !sel_n && sel;
    endfunction

endpackage

// File: rtl/dpr_addr_counter.sv
module dpr_addr_counter
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_op_e           op,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] cnt_q
);

    always_comb begin
        unique case (op)
            CNT_CLEAR: nxt = '0;
            CNT_LOAD:  nxt = load_addr;
            CNT_STEP:  nxt = cnt_q + 1'b1;
            default:   nxt = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt;
    end

endmodule

// File: rtl/dpr_port_front.sv
module dpr_port_front
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              rd_wr,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              ld_n,
    input  logic              adv_n,
    input  logic              clr_n,
    input  logic              pipe_mode,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic [ADDR_W-1:0] rd_addr,
    output rd_ctrl_t          rd_ctrl
);

    logic [LANES-1:0] lane_on;
    logic             sel_now;
    cnt_op_e          op;

    assign lane_on = {~ub_n, ~lb_n};
    assign sel_now = port_selected(sel_n, sel);
    assign op      = decode_cnt(clr_n, ld_n, adv_n);

    dpr_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_addr (addr_in),
        .nxt       (wr_addr),
        .cnt_q     (rd_addr)
    );

    // Writes land in the array on the capturing edge itself.
    assign wr_lanes = (sel_now && !rd_wr && !rst) ? lane_on : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ctrl <= '0;
        end else begin
            rd_ctrl.rd   <= sel_now && rd_wr && !oe_n;
            rd_ctrl.lane <= lane_on;
            rd_ctrl.pipe <= pipe_mode;
        end
    end

endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage
    import dpr_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_in,
    input  rd_ctrl_t          ctrl_in,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  dvld
);

    logic [LANES-1:0]  vld_ft;
    logic [LANES-1:0]  vld_p;
    logic [DATA_W-1:0] word_p;
    logic [DATA_W-1:0] word_sel;

    assign vld_ft = ctrl_in.rd ? ctrl_in.lane : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_p  <= '0;
            word_p <= '0;
        end else begin
            vld_p  <= vld_ft;
            word_p <= word_in;
        end
    end

    assign dvld     = ctrl_in.pipe ? vld_p  : vld_ft;
    assign word_sel = ctrl_in.pipe ? word_p : word_in;

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign dout[l*LANE_W +: LANE_W] = dvld[l] ? word_sel[l*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/dpr_burst_ram.sv
module dpr_burst_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    input  logic              sel_n_a,
    input  logic              sel_a,
    input  logic              rd_wr_a,
    input  logic              oe_n_a,
    input  logic              ub_n_a,
    input  logic              lb_n_a,
    input  logic              ld_n_a,
    input  logic              adv_n_a,
    input  logic              clr_n_a,
    input  logic              pipe_mode_a,
    output logic [DATA_W-1:0] dout_a,
    output logic [LANES-1:0]  dvld_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    input  logic              sel_n_b,
    input  logic              sel_b,
    input  logic              rd_wr_b,
    input  logic              oe_n_b,
    input  logic              ub_n_b,
    input  logic              lb_n_b,
    input  logic              ld_n_b,
    input  logic              adv_n_b,
    input  logic              clr_n_b,
    input  logic              pipe_mode_b,
    output logic [DATA_W-1:0] dout_b,
    output logic [LANES-1:0]  dvld_b
);

    localparam int PORTS = 2;

    logic              clk_v   [PORTS];
    logic              rst_v   [PORTS];
    logic [ADDR_W-1:0] addr_v  [PORTS];
    logic [DATA_W-1:0] din_v   [PORTS];
    logic              seln_v  [PORTS];
    logic              sel_v   [PORTS];
    logic              rdwr_v  [PORTS];
    logic              oen_v   [PORTS];
    logic              ubn_v   [PORTS];
    logic              lbn_v   [PORTS];
    logic              ldn_v   [PORTS];
    logic              advn_v  [PORTS];
    logic              clrn_v  [PORTS];
    logic              mode_v  [PORTS];
    logic [DATA_W-1:0] dout_v  [PORTS];
    logic [LANES-1:0]  dvld_v  [PORTS];

    logic [ADDR_W-1:0] wr_addr_v  [PORTS];
    logic [LANES-1:0]  wr_lanes_v [PORTS];
    logic [ADDR_W-1:0] rd_addr_v  [PORTS];
    rd_ctrl_t          rd_ctrl_v  [PORTS];
    logic [LANE_W-1:0] rd_lane    [PORTS][LANES];

    assign clk_v[0]  = clk_a;       assign clk_v[1]  = clk_b;
    assign rst_v[0]  = rst_a;       assign rst_v[1]  = rst_b;
    assign addr_v[0] = addr_a;      assign addr_v[1] = addr_b;
    assign din_v[0]  = din_a;       assign din_v[1]  = din_b;
    assign seln_v[0] = sel_n_a;     assign seln_v[1] = sel_n_b;
    assign sel_v[0]  = sel_a;       assign sel_v[1]  = sel_b;
    assign rdwr_v[0] = rd_wr_a;     assign rdwr_v[1] = rd_wr_b;
    assign oen_v[0]  = oe_n_a;      assign oen_v[1]  = oe_n_b;
    assign ubn_v[0]  = ub_n_a;      assign ubn_v[1]  = ub_n_b;
    assign lbn_v[0]  = lb_n_a;      assign lbn_v[1]  = lb_n_b;
    assign ldn_v[0]  = ld_n_a;      assign ldn_v[1]  = ld_n_b;
    assign advn_v[0] = adv_n_a;     assign advn_v[1] = adv_n_b;
    assign clrn_v[0] = clr_n_a;     assign clrn_v[1] = clr_n_b;
    assign mode_v[0] = pipe_mode_a; assign mode_v[1] = pipe_mode_b;
    assign dout_a    = dout_v[0];   assign dout_b    = dout_v[1];
    assign dvld_a    = dvld_v[0];   assign dvld_b    = dvld_v[1];

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic [DATA_W-1:0] rd_word;

        dpr_port_front #(.ADDR_W(ADDR_W)) u_front (
            .clk       (clk_v[p]),
            .rst       (rst_v[p]),
            .addr_in   (addr_v[p]),
            .sel_n     (seln_v[p]),
            .sel       (sel_v[p]),
            .rd_wr     (rdwr_v[p]),
            .oe_n      (oen_v[p]),
            .ub_n      (ubn_v[p]),
            .lb_n      (lbn_v[p]),
            .ld_n      (ldn_v[p]),
            .adv_n     (advn_v[p]),
            .clr_n     (clrn_v[p]),
            .pipe_mode (mode_v[p]),
            .wr_addr   (wr_addr_v[p]),
            .wr_lanes  (wr_lanes_v[p]),
            .rd_addr   (rd_addr_v[p]),
            .rd_ctrl   (rd_ctrl_v[p])
        );

        assign rd_word = {rd_lane[p][1], rd_lane[p][0]};

        dpr_read_stage #(.LANE_W(LANE_W)) u_read (
            .clk     (clk_v[p]),
            .rst     (rst_v[p]),
            .word_in (rd_word),
            .ctrl_in (rd_ctrl_v[p]),
            .dout    (dout_v[p]),
            .dvld    (dvld_v[p])
        );
    end

    // Storage: one bank per writing port and per lane. Each port keeps a
    // flag per word; equal flags mean port A wrote last, unequal mean B.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank_a [DEPTH];
        logic [LANE_W-1:0] bank_b [DEPTH];
        logic              flag_a [DEPTH];
        logic              flag_b [DEPTH];

        always_ff @(posedge clk_a) begin
            if (wr_lanes_v[0][l]) begin
                bank_a[wr_addr_v[0]] <= din_a[l*LANE_W +: LANE_W];
                flag_a[wr_addr_v[0]] <= flag_b[wr_addr_v[0]];
            end
        end

        always_ff @(posedge clk_b) begin
            if (wr_lanes_v[1][l]) begin
                bank_b[wr_addr_v[1]] <= din_b[l*LANE_W +: LANE_W];
                flag_b[wr_addr_v[1]] <= ~flag_a[wr_addr_v[1]];
            end
        end

        for (genvar p = 0; p < PORTS; p++) begin : g_rd
            assign rd_lane[p][l] =
                (flag_a[rd_addr_v[p]] == flag_b[rd_addr_v[p]]) ? bank_a[rd_addr_v[p]]
                                                               : bank_b[rd_addr_v[p]];
        end
    end

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9
) (
    input logic                clk_a,
    input logic                rst_a,
    input logic                sel_n_a,
    input logic                sel_a,
    input logic                rd_wr_a,
    input logic                clr_n_a,
    input logic                ld_n_a,
    input logic                adv_n_a,
    input logic                pipe_mode_a,
    input logic [2*LANE_W-1:0] dout_a,
    input logic [1:0]          dvld_a,
    input logic [ADDR_W-1:0]   cnt_a,
    input logic                clk_b,
    input logic                rst_b,
    input logic                sel_n_b,
    input logic                oe_n_b,
    input logic                clr_n_b,
    input logic                ld_n_b,
    input logic                adv_n_b,
    input logic                pipe_mode_b,
    input logic [1:0]          dvld_b,
    input logic [ADDR_W-1:0]   cnt_b
);

    assert_clear_R2: assert property (@(posedge clk_a) disable iff (rst_a)
        !clr_n_a |=> (cnt_a == '0));

    assert_hold_R2: assert property (@(posedge clk_a) disable iff (rst_a)
        (clr_n_a && ld_n_a && adv_n_a) |=> $stable(cnt_a));

    assert_wrap_R3: assert property (@(posedge clk_a) disable iff (rst_a)
        (clr_n_a && ld_n_a && !adv_n_a && cnt_a == {ADDR_W{1'b1}}) |=> (cnt_a == '0));

    assert_desel_quiet_R6: assert property (@(posedge clk_a) disable iff (rst_a)
        (!pipe_mode_a && (sel_n_a || !sel_a)) |=> (dvld_a == 2'b00));

    assert_write_quiet_R8: assert property (@(posedge clk_a) disable iff (rst_a)
        (!pipe_mode_a && !rd_wr_a) |=> (dvld_a == 2'b00));

    assert_oe_quiet_R8: assert property (@(posedge clk_b) disable iff (rst_b)
        (!pipe_mode_b && oe_n_b) |=> (dvld_b == 2'b00));

    assert_lane0_zero_R7: assert property (@(posedge clk_a) disable iff (rst_a)
        !dvld_a[0] |-> (dout_a[LANE_W-1:0] == '0));

    assert_lane1_zero_R7: assert property (@(posedge clk_a) disable iff (rst_a)
        !dvld_a[1] |-> (dout_a[2*LANE_W-1:LANE_W] == '0));

    assert_reset_quiet_R9: assert property (@(posedge clk_a)
        rst_a |=> (dvld_a == 2'b00));

    assert_desel_count_R10: assert property (@(posedge clk_b) disable iff (rst_b)
        (sel_n_b && clr_n_b && ld_n_b && !adv_n_b) |=> (cnt_b == ADDR_W'($past(cnt_b) + 1'b1)));

endmodule

bind dpr_burst_ram dpr_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk_a       (clk_a),
    .rst_a       (rst_a),
    .sel_n_a     (sel_n_a),
    .sel_a       (sel_a),
    .rd_wr_a     (rd_wr_a),
    .clr_n_a     (clr_n_a),
    .ld_n_a      (ld_n_a),
    .adv_n_a     (adv_n_a),
    .pipe_mode_a (pipe_mode_a),
    .dout_a      (dout_a),
    .dvld_a      (dvld_a),
    .cnt_a       (rd_addr_v[0]),
    .clk_b       (clk_b),
    .rst_b       (rst_b),
    .sel_n_b     (sel_n_b),
    .oe_n_b      (oe_n_b),
    .clr_n_b     (clr_n_b),
    .ld_n_b      (ld_n_b),
    .adv_n_b     (adv_n_b),
    .pipe_mode_b (pipe_mode_b),
    .dvld_b      (dvld_b),
    .cnt_b       (rd_addr_v[1])
);

// File: tb/tb_dpr_burst_ram.sv
`timescale 1ns/1ps
module tb_dpr_burst_ram;

    localparam int AW    = 8;
    localparam int LW    = 9;
    localparam int DW    = 2 * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] i_addr [2];
    logic [DW-1:0] i_din  [2];
    logic i_seln [2], i_sel [2], i_rdwr [2], i_oen [2], i_ubn [2], i_lbn [2];
    logic i_ldn [2], i_advn [2], i_clrn [2], i_mode [2];
    logic [DW-1:0] o_dout [2];
    logic [1:0]    o_vld  [2];

    dpr_burst_ram #(.ADDR_W(AW), .LANE_W(LW)) dut (
        .clk_a(clk), .rst_a(rst), .addr_a(i_addr[0]), .din_a(i_din[0]),
        .sel_n_a(i_seln[0]), .sel_a(i_sel[0]), .rd_wr_a(i_rdwr[0]), .oe_n_a(i_oen[0]),
        .ub_n_a(i_ubn[0]), .lb_n_a(i_lbn[0]), .ld_n_a(i_ldn[0]), .adv_n_a(i_advn[0]),
        .clr_n_a(i_clrn[0]), .pipe_mode_a(i_mode[0]), .dout_a(o_dout[0]), .dvld_a(o_vld[0]),
        .clk_b(clk), .rst_b(rst), .addr_b(i_addr[1]), .din_b(i_din[1]),
        .sel_n_b(i_seln[1]), .sel_b(i_sel[1]), .rd_wr_b(i_rdwr[1]), .oe_n_b(i_oen[1]),
        .ub_n_b(i_ubn[1]), .lb_n_b(i_lbn[1]), .ld_n_b(i_ldn[1]), .adv_n_b(i_advn[1]),
        .clr_n_b(i_clrn[1]), .pipe_mode_b(i_mode[1]), .dout_b(o_dout[1]), .dvld_b(o_vld[1])
    );

    // Reference model
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] m_cnt  [2];
    logic [DW-1:0] e_ft_w [2], e_pp_w [2];
    logic [1:0]    e_ft_v [2], e_pp_v [2];
    logic          m_mode [2];

    int total = 0;
    int bad   = 0;
    string tag = "R9";

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] en);
        return {{LW{en[1]}}, {LW{en[0]}}};
    endfunction

    function automatic logic [AW-1:0] peek_next(input int p);
        if (!i_clrn[p])     return '0;
        else if (!i_ldn[p]) return i_addr[p];
        else if (!i_advn[p]) return m_cnt[p] + 1'b1;
        return m_cnt[p];
    endfunction

    function automatic logic is_sel(input int p);
        return !i_seln[p] && i_sel[p];
    endfunction

    task automatic model_edge();
        logic [AW-1:0] n [2];
        logic [1:0] en;
        for (int p = 0; p < 2; p++) n[p] = rst ? '0 : peek_next(p);
        if (!rst) begin
            for (int p = 0; p < 2; p++) begin
                if (is_sel(p) && !i_rdwr[p]) begin
                    en = {~i_ubn[p], ~i_lbn[p]};
                    ref_mem[n[p]] = (ref_mem[n[p]] & ~lane_mask(en)) | (i_din[p] & lane_mask(en));
                end
            end
        end
        for (int p = 0; p < 2; p++) begin
            if (rst) begin
                e_ft_v[p] = '0; e_ft_w[p] = '0; e_pp_v[p] = '0; e_pp_w[p] = '0;
                m_mode[p] = 1'b0;
            end else begin
                e_pp_v[p] = e_ft_v[p];
                e_pp_w[p] = e_ft_w[p];
                en = {~i_ubn[p], ~i_lbn[p]};
                e_ft_v[p] = (is_sel(p) && i_rdwr[p] && !i_oen[p]) ? en : 2'b00;
                e_ft_w[p] = ref_mem[n[p]] & lane_mask(e_ft_v[p]);
                m_mode[p] = i_mode[p];
            end
            m_cnt[p] = n[p];
        end
    endtask

    task automatic compare(input int p);
        logic [1:0]    ev;
        logic [DW-1:0] ew;
        ev = m_mode[p] ? e_pp_v[p] : e_ft_v[p];
        ew = m_mode[p] ? e_pp_w[p] : e_ft_w[p];
        total++;
        if (o_vld[p] !== ev || o_dout[p] !== ew) begin
            bad++;
            $display("FAIL %s port %0d: vld=%b dout=%h expected vld=%b dout=%h",
                     tag, p, o_vld[p], o_dout[p], ev, ew);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(0);
        compare(1);
    endtask

    task automatic idle(input int p);
        i_seln[p] = 1'b1; i_sel[p] = 1'b0; i_rdwr[p] = 1'b1; i_oen[p] = 1'b1;
        i_ubn[p] = 1'b0;  i_lbn[p] = 1'b0; i_ldn[p] = 1'b1;  i_advn[p] = 1'b1;
        i_clrn[p] = 1'b1; i_addr[p] = '0;  i_din[p] = '0;
    endtask

    // Selected access with both lanes and output enabled.
    task automatic drive(input int p, input logic rw, input logic ldn, input logic advn,
                         input logic clrn, input logic [AW-1:0] a, input logic [DW-1:0] d);
        i_seln[p] = 1'b0; i_sel[p] = 1'b1; i_rdwr[p] = rw; i_oen[p] = 1'b0;
        i_ubn[p] = 1'b0;  i_lbn[p] = 1'b0; i_ldn[p] = ldn; i_advn[p] = advn;
        i_clrn[p] = clrn; i_addr[p] = a;   i_din[p] = d;
    endtask

    task automatic rand_port(input int p);
        i_clrn[p] = 1'($urandom_range(15) != 0);
        i_ldn[p]  = 1'($urandom_range(3) != 0);
        i_advn[p] = 1'($urandom_range(1));
        i_addr[p] = AW'($urandom_range(DEPTH - 1));
        i_seln[p] = 1'($urandom_range(7) == 0);
        i_sel[p]  = 1'($urandom_range(7) != 0);
        i_rdwr[p] = 1'($urandom_range(1));
        i_oen[p]  = 1'($urandom_range(7) == 0);
        i_ubn[p]  = 1'($urandom_range(3) == 0);
        i_lbn[p]  = 1'($urandom_range(3) == 0);
        i_din[p]  = DW'($urandom);
        if ($urandom_range(31) == 0) i_mode[p] = ~i_mode[p];
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        for (int p = 0; p < 2; p++) begin
            idle(p);
            i_mode[p] = 1'b0;
            m_cnt[p] = '0; m_mode[p] = 1'b0;
            e_ft_v[p] = '0; e_ft_w[p] = '0; e_pp_v[p] = '0; e_pp_w[p] = '0;
        end

        // R9: outputs quiet under reset
        tag = "R9 reset";
        @(negedge clk);
        for (int k = 0; k < 3; k++) cycle();
        rst = 1'b0;

        // R2: fill every word with a clear then an advancing burst of writes
        tag = "R2 fill";
        drive(0, 1'b0, 1'b1, 1'b1, 1'b0, '0, DW'($urandom));
        cycle();
        for (int i = 1; i < DEPTH; i++) begin
            drive(0, 1'b0, 1'b1, 1'b0, 1'b1, '0, DW'($urandom));
            cycle();
        end

        // R9: reset again, counter back at 0
        idle(0);
        rst = 1'b1;
        tag = "R9 reset";
        cycle(); cycle();
        rst = 1'b0;
        tag = "R9 read after reset";
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd77, '0);
        cycle();
        idle(0); cycle();

        // R4: flow-through burst read
        tag = "R4 flow burst";
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd10, '0); cycle();
        for (int k = 0; k < 4; k++) begin drive(0, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0); cycle(); end
        idle(0); cycle();

        // R5: pipelined burst read
        tag = "R5 pipe burst";
        i_mode[0] = 1'b1;
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd20, '0); cycle();
        for (int k = 0; k < 4; k++) begin drive(0, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0); cycle(); end
        idle(0); cycle(); cycle();
        i_mode[0] = 1'b0;
        cycle();

        // R3: wrap from the top word to word 0
        tag = "R3 wrap";
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, AW'(DEPTH - 1), '0); cycle();
        drive(0, 1'b1, 1'b1, 1'b0, 1'b1, '0, '0); cycle();
        idle(0); cycle();

        // R7: lane 0 only write, then full and lane 1 only reads from B
        tag = "R7 lanes";
        drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd30, {DW{1'b1}});
        i_ubn[0] = 1'b1; cycle();
        idle(0);
        drive(1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd30, '0); cycle();
        drive(1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        i_lbn[1] = 1'b1; cycle();
        idle(1); cycle();

        // R1: cross-port read after write, and both ports on one word
        tag = "R1 cross port";
        drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd40, 18'h2b3c1);
        drive(1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd41, '0); cycle();
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        drive(1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd40, '0); cycle();
        drive(1, 1'b0, 1'b1, 1'b1, 1'b1, '0, 18'h0155a);
        idle(0); cycle();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd40, '0);
        idle(1); cycle();
        idle(0); cycle();

        // R6: writes while deselected by either select have no effect
        tag = "R6 deselect";
        drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd50, 18'h3a5a5);
        i_sel[0] = 1'b0; cycle();
        drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd50, 18'h15a5a);
        i_seln[0] = 1'b1; cycle();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd50, '0);
        i_seln[0] = 1'b1; cycle();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd50, '0); cycle();
        idle(0); cycle();

        // R8: read with output disabled, and a write, give no valid lanes
        tag = "R8 oe and write";
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd60, '0);
        i_oen[0] = 1'b1; cycle();
        drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd61, 18'h00f0f); cycle();
        drive(0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0); cycle();
        idle(0); cycle();

        // R10: counter loads and advances while deselected
        tag = "R10 deselected counter";
        idle(1); i_ldn[1] = 1'b0; i_addr[1] = 8'd70; cycle();
        for (int k = 0; k < 3; k++) begin idle(1); i_advn[1] = 1'b0; cycle(); end
        drive(1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0); cycle();
        idle(1); cycle();

        // R2: priority with several counter controls low together
        tag = "R2 priority";
        drive(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd90, '0); cycle();
        drive(0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd90, '0); cycle();
        idle(0); cycle();

        // Random traffic on both ports
        tag = "R1/R2/R4/R5/R7 random";
        for (int k = 0; k < 4000; k++) begin
            rand_port(0);
            rand_port(1);
            if (is_sel(0) && is_sel(1) && !i_rdwr[0] && !i_rdwr[1] && peek_next(0) == peek_next(1))
                i_rdwr[1] = 1'b1;
            cycle();
        end
        idle(0); idle(1);
        cycle(); cycle();

        finish_run();
    end

endmodule